// File: doc/BRIEF.md
# Two-Channel Staged Configuration Register Bank

This block is the byte-wide configuration store of a two-channel data converter. An external serial front end, which is not part of this block, turns host transactions into a plain register port: a 9-bit address, a write byte with a write strobe, and a read strobe. The bank keeps every setting and drives the active values onto per-channel and shared output buses. The converter logic reads those buses.

Part of the converter-function range is staged. A write there lands in a staging copy, and the outputs stay as they are. A later write to the commit register, with bit 0 set, moves every staged register into its active copy on one clock edge. Settings that must change together therefore change together. Per-channel registers exist twice, once for each channel. A channel-select register sets which copies a write reaches, and a write can reach both copies at once. On a read, channel A takes priority. Shared registers have a single copy and take no notice of the channel selection.

Register map:

| Address | Kind | Bits | Reset value |
|---|---|---|---|
| 0x000 | shared, immediate | 7:0 | 0x00 |
| 0x005 | channel select | 0 = channel A, 1 = channel B | 0x03 |
| 0x008 + i, i < 4 | per-channel, staged | 7:0 | 0x10 + i |
| 0x018 | shared, staged (reference select) | 7:6 | 0xC0 |
| 0x0FF | commit | 0 | reads 0x00 |
| 0x100 + i, i < 4 | per-channel, immediate (feature) | 7:0 | 0x00 |

Top module: `cfg_bank_2ch`

## Requirements
- R1: After reset the registers hold their reset values: 0x000 = 0x00, channel select 0x005 = 0x03, staged per-channel register i = 0x10+i (staging and active copies, both channels), reference select 0x018 = 0xC0 (staging and active), feature registers = 0x00.
- R2: A read of an unimplemented address returns 0x00. A write to such an address changes nothing. Unimplemented bits read as 0: bits 7:2 of 0x005 and bits 5:0 of 0x018.
- R3: Writes to the staged registers (0x008..0x00B and 0x018) change only the staging copies. The active outputs keep their values until a commit. Reads of a staged register return the staging copy.
- R4: A write to 0x0FF with bit 0 set copies every staging copy into its active copy on that clock edge. A write to 0x0FF with bit 0 clear changes nothing. A read of 0x0FF returns 0x00, because the commit bit clears itself.
- R5: A write to a per-channel register updates the copy of channel A when bit 0 of 0x005 is set, and the copy of channel B when bit 1 is set. When both bits are set, both copies change.
- R6: A read of a per-channel register returns the channel A copy when bit 0 of 0x005 is set. It returns the channel B copy when only bit 1 is set, and 0x00 when neither bit is set.
- R7: A write to a per-channel register while 0x005 bits 1:0 are 00 changes neither copy.
- R8: The shared registers 0x000 and 0x018 each have one copy. They take writes and return reads whatever value 0x005 holds.
- R9: The feature registers 0x100..0x103 are per-channel and not staged. A write reaches the feature output bus at the clock edge of the write.
- R10: Read data updates at the clock edge where the read strobe is high. It holds its value while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 9 | Register address |
| wdata | input | 8 | Write byte |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, registered |
| loc_a | output | 32 | Active staged per-channel registers of channel A, byte i at bits 8i+7:8i |
| loc_b | output | 32 | Active staged per-channel registers of channel B |
| feat_a | output | 32 | Feature registers of channel A, byte i at bits 8i+7:8i |
| feat_b | output | 32 | Feature registers of channel B |
| vref_sel | output | 8 | Active shared reference-select register |
| gcfg | output | 8 | Shared immediate register 0x000 |

## Verification
Read data is due at the rising edge where the read strobe is high. The active buses change at the edge that takes a commit write. Feature and shared immediate outputs change at the edge of their own write. Every register therefore sits one register stage from the port. The bench drives each access just after a falling edge and compares at the next falling edge, which is half a period after the edge where the result is due. Before it drives the next access, it updates a reference model from the requirements and compares every output bus and the read byte with that model.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
    localparam int IDX_W = 4;

    typedef enum logic [2:0] {
        K_NONE, K_GCFG, K_CHSEL, K_XFER, K_LOC, K_VREF, K_FEAT
    } kind_e;

    typedef struct packed {
        kind_e            kind;
        logic [IDX_W-1:0] idx;
    } dec_t;

    localparam logic [7:0] GCFG_RST   = 8'h00;
    localparam logic [7:0] CHSEL_RST  = 8'h03;
    localparam logic [7:0] CHSEL_MASK = 8'h03;
    localparam logic [7:0] VREF_RST   = 8'hC0;
    localparam logic [7:0] VREF_MASK  = 8'hC0;

    function automatic logic [7:0] loc_rst(input int i);
        return 8'h10 + 8'(i);
    endfunction
endpackage

// File: rtl/cfg_decode.sv
module cfg_decode
    import cfg_bank_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int NLOC   = 4,
    parameter int NFEAT  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] LOC_BASE  = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] FEAT_BASE = ADDR_W'(256);

    always_comb begin
        dec.kind = K_NONE;
        dec.idx  = '0;
        if (addr == ADDR_W'(0))
            dec.kind = K_GCFG;
        else if (addr == ADDR_W'(5))
            dec.kind = K_CHSEL;
        else if (addr == ADDR_W'(255))
            dec.kind = K_XFER;
        else if (addr == ADDR_W'(24))
            dec.kind = K_VREF;
        else if (addr >= LOC_BASE && addr < LOC_BASE + ADDR_W'(NLOC)) begin
            dec.kind = K_LOC;
            dec.idx  = IDX_W'(addr - LOC_BASE);
        end else if (addr >= FEAT_BASE && addr < FEAT_BASE + ADDR_W'(NFEAT)) begin
            dec.kind = K_FEAT;
            dec.idx  = IDX_W'(addr - FEAT_BASE);
        end
    end
endmodule

// File: rtl/cfg_chan.sv
module cfg_chan
    import cfg_bank_pkg::*;
#(
    parameter int NLOC  = 4,
    parameter int NFEAT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               loc_we,
    input  logic               feat_we,
    input  logic [IDX_W-1:0]   idx,
    input  logic [7:0]         wdata,
    input  logic               commit,
    output logic [8*NLOC-1:0]  shadow_o,
    output logic [8*NLOC-1:0]  active_o,
    output logic [8*NFEAT-1:0] feat_o
);
    typedef struct packed {
        logic [NLOC-1:0][7:0]  sh;
        logic [NLOC-1:0][7:0]  act;
        logic [NFEAT-1:0][7:0] ft;
    } chan_st_t;

    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit)
            st_d.act = st_q.sh;
        for (int i = 0; i < NLOC; i++)
            if (loc_we && idx == IDX_W'(i))
                st_d.sh[i] = wdata;
        for (int i = 0; i < NFEAT; i++)
            if (feat_we && idx == IDX_W'(i))
                st_d.ft[i] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NLOC; i++) begin
                st_q.sh[i]  <= loc_rst(i);
                st_q.act[i] <= loc_rst(i);
            end
            st_q.ft <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shadow_o = st_q.sh;
    assign active_o = st_q.act;
    assign feat_o   = st_q.ft;

    // R3: active copies move only on a commit
    a_r3_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(active_o));

    // R4: a commit loads the staged values present at that edge
    a_r4_commit_copy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> active_o == $past(shadow_o));
endmodule

// File: rtl/cfg_bank_2ch.sv
module cfg_bank_2ch
    import cfg_bank_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int NLOC   = 4,
    parameter int NFEAT  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [7:0]         wdata,
    input  logic               wr_en,
    input  logic               rd_en,
    output logic [7:0]         rdata,
    output logic [8*NLOC-1:0]  loc_a,
    output logic [8*NLOC-1:0]  loc_b,
    output logic [8*NFEAT-1:0] feat_a,
    output logic [8*NFEAT-1:0] feat_b,
    output logic [7:0]         vref_sel,
    output logic [7:0]         gcfg
);
    localparam int NCH = 2;

    typedef struct packed {
        logic [7:0] gcfg;
        logic [7:0] chsel;
        logic [7:0] vsh;
        logic [7:0] vact;
        logic [7:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;
    dec_t    dec;
    logic    commit;
    logic [NCH-1:0]              loc_we, feat_we;
    logic [NCH-1:0][8*NLOC-1:0]  sh_w, act_w;
    logic [NCH-1:0][8*NFEAT-1:0] ft_w;
    logic [7:0]                  rd_byte;

    cfg_decode #(.ADDR_W(ADDR_W), .NLOC(NLOC), .NFEAT(NFEAT)) u_dec (
        .addr (addr),
        .dec  (dec)
    );

    assign commit = wr_en && dec.kind == K_XFER && wdata[0];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign loc_we[c]  = wr_en && dec.kind == K_LOC  && st_q.chsel[c];
        assign feat_we[c] = wr_en && dec.kind == K_FEAT && st_q.chsel[c];
        cfg_chan #(.NLOC(NLOC), .NFEAT(NFEAT)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .loc_we   (loc_we[c]),
            .feat_we  (feat_we[c]),
            .idx      (dec.idx),
            .wdata    (wdata),
            .commit   (commit),
            .shadow_o (sh_w[c]),
            .active_o (act_w[c]),
            .feat_o   (ft_w[c])
        );
    end

    always_comb begin
        rd_byte = 8'h00;
        case (dec.kind)
            K_GCFG:  rd_byte = st_q.gcfg;
            K_CHSEL: rd_byte = st_q.chsel;
            K_VREF:  rd_byte = st_q.vsh;
            K_LOC: begin
                for (int i = 0; i < NLOC; i++)
                    if (dec.idx == IDX_W'(i))
                        rd_byte = st_q.chsel[0] ? sh_w[0][8*i +: 8] :
                                  st_q.chsel[1] ? sh_w[1][8*i +: 8] : 8'h00;
            end
            K_FEAT: begin
                for (int i = 0; i < NFEAT; i++)
                    if (dec.idx == IDX_W'(i))
                        rd_byte = st_q.chsel[0] ? ft_w[0][8*i +: 8] :
                                  st_q.chsel[1] ? ft_w[1][8*i +: 8] : 8'h00;
            end
            default: rd_byte = 8'h00;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (rd_en)
            st_d.rdata = rd_byte;
        if (commit)
            st_d.vact = st_q.vsh;
        if (wr_en) begin
            case (dec.kind)
                K_GCFG:  st_d.gcfg  = wdata;
                K_CHSEL: st_d.chsel = wdata & CHSEL_MASK;
                K_VREF:  st_d.vsh   = wdata & VREF_MASK;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.gcfg  <= GCFG_RST;
            st_q.chsel <= CHSEL_RST;
            st_q.vsh   <= VREF_RST;
            st_q.vact  <= VREF_RST;
            st_q.rdata <= 8'h00;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata    = st_q.rdata;
    assign loc_a    = act_w[0];
    assign loc_b    = act_w[1];
    assign feat_a   = ft_w[0];
    assign feat_b   = ft_w[1];
    assign vref_sel = st_q.vact;
    assign gcfg     = st_q.gcfg;

    // R2: unimplemented addresses read as zero
    a_r2_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && dec.kind == K_NONE |=> rdata == 8'h00);

    // R4: the commit bit never reads back set
    a_r4_xfer_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && dec.kind == K_XFER |=> rdata == 8'h00);

    // R6: no channel selected gives zero on a per-channel read
    a_r6_nosel_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && dec.kind == K_LOC && st_q.chsel[1:0] == 2'b00 |=> rdata == 8'h00);

    // R7: a write with no channel selected leaves both staging copies alone
    a_r7_nosel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && dec.kind == K_LOC && st_q.chsel[1:0] == 2'b00
        |=> $stable(sh_w[0]) && $stable(sh_w[1]));

    // R10: read data holds while no read is strobed
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

// File: tb/cfg_bank_2ch_test.sv
module cfg_bank_2ch_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 9;
    localparam int NLOC   = 4;
    localparam int NFEAT  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] rdata, vref_sel, gcfg;
    logic [8*NLOC-1:0] loc_a, loc_b;
    logic [8*NFEAT-1:0] feat_a, feat_b;

    int total = 0, bad = 0;

    logic [7:0] m_sh  [2][NLOC];
    logic [7:0] m_act [2][NLOC];
    logic [7:0] m_ft  [2][NFEAT];
    logic [7:0] m_gcfg, m_chsel, m_vsh, m_vact, m_rdata;

    cfg_bank_2ch #(.ADDR_W(ADDR_W), .NLOC(NLOC), .NFEAT(NFEAT)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
        .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
        .loc_a(loc_a), .loc_b(loc_b), .feat_a(feat_a), .feat_b(feat_b),
        .vref_sel(vref_sel), .gcfg(gcfg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic void model_reset();
        for (int c = 0; c < 2; c++) begin
            for (int i = 0; i < NLOC; i++) begin
                m_sh[c][i]  = 8'h10 + 8'(i);
                m_act[c][i] = 8'h10 + 8'(i);
            end
            for (int i = 0; i < NFEAT; i++) m_ft[c][i] = 8'h00;
        end
        m_gcfg = 8'h00; m_chsel = 8'h03; m_vsh = 8'hC0; m_vact = 8'hC0; m_rdata = 8'h00;
    endfunction

    function automatic logic [7:0] exp_read(input logic [ADDR_W-1:0] a);
        int ia = int'(a);
        if (ia == 0)   return m_gcfg;
        if (ia == 5)   return m_chsel;
        if (ia == 255) return 8'h00;
        if (ia == 24)  return m_vsh;
        if (ia >= 8 && ia < 8 + NLOC)
            return m_chsel[0] ? m_sh[0][ia-8] : m_chsel[1] ? m_sh[1][ia-8] : 8'h00;
        if (ia >= 256 && ia < 256 + NFEAT)
            return m_chsel[0] ? m_ft[0][ia-256] : m_chsel[1] ? m_ft[1][ia-256] : 8'h00;
        return 8'h00;
    endfunction

    function automatic void model_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        int ia = int'(a);
        if (ia == 0) m_gcfg = d;
        else if (ia == 5) m_chsel = d & 8'h03;
        else if (ia == 255) begin
            if (d[0]) begin
                for (int c = 0; c < 2; c++)
                    for (int i = 0; i < NLOC; i++) m_act[c][i] = m_sh[c][i];
                m_vact = m_vsh;
            end
        end else if (ia == 24) m_vsh = d & 8'hC0;
        else if (ia >= 8 && ia < 8 + NLOC) begin
            for (int c = 0; c < 2; c++) if (m_chsel[c]) m_sh[c][ia-8] = d;
        end else if (ia >= 256 && ia < 256 + NFEAT) begin
            for (int c = 0; c < 2; c++) if (m_chsel[c]) m_ft[c][ia-256] = d;
        end
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic check_outs(input string req);
        logic [8*NLOC-1:0] ea, eb;
        logic [8*NFEAT-1:0] fa, fb;
        for (int i = 0; i < NLOC; i++) begin
            ea[8*i +: 8] = m_act[0][i];
            eb[8*i +: 8] = m_act[1][i];
        end
        for (int i = 0; i < NFEAT; i++) begin
            fa[8*i +: 8] = m_ft[0][i];
            fb[8*i +: 8] = m_ft[1][i];
        end
        total++;
        if (loc_a !== ea || loc_b !== eb || feat_a !== fa || feat_b !== fb ||
            vref_sel !== m_vact || gcfg !== m_gcfg) begin
            bad++;
            $display("FAIL %s outputs: actual=%h %h %h %h %h %h expected=%h %h %h %h %h %h",
                     req, loc_a, loc_b, feat_a, feat_b, vref_sel, gcfg,
                     ea, eb, fa, fb, m_vact, m_gcfg);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        addr = ADDR_W'(a); wdata = d; wr_en = 1'b1;
        @(posedge clk);
        model_write(ADDR_W'(a), d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input string req);
        logic [7:0] e;
        addr = ADDR_W'(a); rd_en = 1'b1;
        e = exp_read(ADDR_W'(a));
        @(posedge clk);
        m_rdata = e;
        @(negedge clk);
        rd_en = 1'b0;
        check8(req, rdata, e);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        check_outs("R1");
        check8("R1 rdata", rdata, 8'h00);
        rd(0, "R1"); rd(5, "R1"); rd(24, "R1");
        for (int i = 0; i < NLOC; i++) rd(8 + i, "R1");
        rd(256, "R1");

        // R2 unimplemented space and bits
        rd(19, "R2"); rd(300, "R2"); rd(6, "R2");
        wr(19, 8'h5A); check_outs("R2"); rd(19, "R2");
        wr(5, 8'hFF); rd(5, "R2");
        wr(24, 8'hFF); rd(24, "R2");

        // R3 staging leaves outputs alone
        wr(9, 8'hA5); wr(24, 8'h40);
        check_outs("R3");
        check8("R3 loc_a hold", loc_a[15:8], 8'h11);
        rd(9, "R3");
        check8("R3 staged read", rdata, 8'hA5);

        // R4 commit
        wr(255, 8'hFE); check_outs("R4");
        check8("R4 no commit", vref_sel, 8'hC0);
        wr(255, 8'h01); check_outs("R4");
        check8("R4 committed", loc_b[15:8], 8'hA5);
        check8("R4 vref committed", vref_sel, 8'h40);
        rd(255, "R4");

        // R5 fan-out
        wr(5, 8'h01); wr(10, 8'h3C);
        wr(5, 8'h02); wr(11, 8'hC3);
        wr(5, 8'h03); wr(8, 8'h77);
        wr(255, 8'h01); check_outs("R5");
        check8("R5 A only", loc_a[23:16], 8'h3C);
        check8("R5 B kept", loc_b[23:16], 8'h12);
        check8("R5 B only", loc_b[31:24], 8'hC3);
        check8("R5 both", loc_b[7:0], 8'h77);

        // R6 read priority
        wr(5, 8'h01); wr(257, 8'h11);
        wr(5, 8'h02); wr(257, 8'h22);
        wr(5, 8'h03); rd(257, "R6"); check8("R6 A prio", rdata, 8'h11);
        rd(10, "R6");
        wr(5, 8'h02); rd(257, "R6"); rd(10, "R6");
        wr(5, 8'h00); rd(257, "R6"); rd(10, "R6");

        // R7 no channel selected
        wr(9, 8'hEE); wr(256, 8'hEE); check_outs("R7");
        wr(5, 8'h01); rd(9, "R7");
        wr(5, 8'h02); rd(9, "R7");

        // R8 shared registers ignore selection
        wr(5, 8'h00); wr(0, 8'h9B); wr(24, 8'h80);
        rd(0, "R8"); rd(24, "R8"); check_outs("R8");

        // R9 feature writes are immediate
        wr(5, 8'h03); wr(259, 8'h6D); check_outs("R9");
        check8("R9 feat", feat_b[31:24], 8'h6D);

        // R10 read data holds
        rd(0, "R10");
        repeat (3) @(negedge clk);
        check8("R10 hold", rdata, m_rdata);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int sel = int'($urandom % 10);
            int a;
            logic [7:0] d = 8'($urandom);
            case (sel)
                0, 1, 2, 3: a = 8 + int'($urandom % NLOC);
                4: a = 5;
                5: a = 255;
                6: a = 24;
                7: a = 256 + int'($urandom % NFEAT);
                8: a = 0;
                default: a = int'($urandom % 512);
            endcase
            if ($urandom % 2 == 0) begin
                wr(a, d);
                check_outs("R3 random");
            end else begin
                rd(a, "R10 random");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule